// File: doc/BRIEF.md
# Scalar Float Compare Mask Unit

This unit compares the lowest 32-bit lane of a 128-bit destination value against a 32-bit source value, both read as IEEE-754 single-precision numbers. An 8-bit predicate immediate selects one of eight relations. The unit turns the outcome into a lane-wide bitmask: all ones when the relation holds, all zeros when it does not. It writes that mask over the low lane of the destination and copies the upper 96 bits through unchanged.

NaN operands follow ordered and unordered semantics. An invalid-operation flag reports signaling NaNs. It also reports quiet NaNs under the relations that order values by magnitude. A result is captured on every cycle that the input strobe is high, and it appears one clock later together with an output valid flag. Between strobes the outputs hold their last values.

Top module: `fcmp_mask_unit`

## Requirements
- R1: The relation is chosen by immediate bits 2:0, with this code mapping: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered. The destination lane is the left-hand operand.
- R2: When the relation is true, result bits 31:0 are 32'hFFFF_FFFF. When it is false, they are 32'h0000_0000.
- R3: Result bits 127:32 equal dst_in bits 127:32 as sampled on the strobe that produced the result.
- R4: Immediate bits 7:3 have no effect on the mask or on the invalid flag.
- R5: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. Code 3 is true exactly when at least one operand is a NaN. Code 7 is true exactly when neither operand is a NaN.
- R6: When either operand is a NaN, codes 4, 5 and 6 return true, and codes 0, 1 and 2 return false.
- R7: +0.0 and -0.0 compare equal. Negative values order below positive values, and among negatives a larger magnitude is smaller. Infinities compare as ordinary ordered values.
- R8: invalid_flag is set when either operand is a signaling NaN (a NaN with fraction bit 22 clear), under any code. It is also set for a quiet NaN (a NaN with fraction bit 22 set) under codes 1, 2, 5 and 6. In every other case it is clear.
- R9: out_valid is high in exactly the cycle after a cycle with in_valid high. result and invalid_flag update only on such strobes and otherwise hold their values.
- R10: While reset is asserted, and until the first strobe after reset, out_valid, result and invalid_flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Strobe that captures a new comparison |
| dst_in | input | 128 | Destination value; bits 31:0 are the left operand |
| src_in | input | 32 | Source operand |
| pred_imm | input | 8 | Predicate immediate; bits 2:0 select the relation |
| out_valid | output | 1 | High for one cycle after each strobe |
| result | output | 128 | Upper 96 destination bits merged with the 32-bit mask |
| invalid_flag | output | 1 | Invalid-operation indication for the captured comparison |

## Verification
The mask update and the invalid flag are decided in the same capture cycle. Each of them can also change on back-to-back strobes while the previous result is still being presented. The bench provokes this by streaming consecutive strobes that alternate quiet NaNs, signaling NaNs and ordinary numbers across all eight codes, with random upper destination bits and random immediate bits 7:3. A behavioural reference model decodes each operand to a real number and, on every clock, predicts the valid flag, the full 128-bit result and the invalid flag. Every cycle is compared against that prediction, including idle cycles where the outputs must hold.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned FP_W   = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned MAG_W  = FP_W - 1;

  typedef enum logic [2:0] {
    REL_EQ    = 3'd0,
    REL_LT    = 3'd1,
    REL_LE    = 3'd2,
    REL_UNORD = 3'd3,
    REL_NEQ   = 3'd4,
    REL_NLT   = 3'd5,
    REL_NLE   = 3'd6,
    REL_ORD   = 3'd7
  } rel_code_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_snan;
    logic             is_qnan;
    logic             is_zero;
    logic [MAG_W-1:0] mag;
  } fp_class_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [FP_W-1:0] op,
  output fp_class_t       cls
);
  localparam int unsigned QUIET_BIT = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_full;
  logic              frac_any;

  always_comb begin
    exp_f       = op[FP_W-2 -: EXP_W];
    frac_f      = op[FRAC_W-1:0];
    exp_full    = &exp_f;
    frac_any    = |frac_f;
    cls.sign    = op[FP_W-1];
    cls.mag     = op[MAG_W-1:0];
    cls.is_nan  = exp_full & frac_any;
    cls.is_qnan = exp_full & frac_any & frac_f[QUIET_BIT];
    cls.is_snan = exp_full & frac_any & ~frac_f[QUIET_BIT];
    cls.is_zero = ~|op[MAG_W-1:0];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
(
  input  fp_class_t lhs,
  input  fp_class_t rhs,
  output logic      unord,
  output logic      eq,
  output logic      lt
);
  logic both_zero;
  logic mag_lt;
  logic mag_gt;
  logic mag_eq;

  always_comb begin
    unord     = lhs.is_nan | rhs.is_nan;
    both_zero = lhs.is_zero & rhs.is_zero;
    mag_lt    = lhs.mag < rhs.mag;
    mag_gt    = lhs.mag > rhs.mag;
    mag_eq    = lhs.mag == rhs.mag;
    eq        = both_zero | (mag_eq & (lhs.sign == rhs.sign));
    unique case ({lhs.sign, rhs.sign})
      2'b00:   lt = mag_lt;
      2'b11:   lt = mag_gt;
      2'b10:   lt = ~both_zero;
      default: lt = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcmp_pred_eval.sv
module fcmp_pred_eval
  import fcmp_pkg::*;
(
  input  rel_code_e code,
  input  logic      unord,
  input  logic      eq,
  input  logic      lt,
  input  logic      any_snan,
  input  logic      any_qnan,
  output logic      hit,
  output logic      invalid
);
  logic ordered;
  logic base;
  logic magnitude_rel;

  always_comb begin
    ordered = ~unord;
    unique case (code)
      REL_EQ, REL_NEQ: base = eq;
      REL_LT, REL_NLT: base = lt;
      REL_LE, REL_NLE: base = lt | eq;
      REL_UNORD:       base = unord;
      default:         base = ordered;
    endcase
    unique case (code)
      REL_EQ, REL_LT, REL_LE:    hit = ordered & base;
      REL_NEQ, REL_NLT, REL_NLE: hit = unord | ~base;
      default:                   hit = base;
    endcase
    magnitude_rel = (code == REL_LT) | (code == REL_LE) |
                    (code == REL_NLT) | (code == REL_NLE);
    invalid = any_snan | (any_qnan & magnitude_rel);
  end
endmodule

// File: rtl/fcmp_rst_sync.sv
module fcmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fcmp_mask_unit.sv
module fcmp_mask_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [FP_W-1:0]   src_in,
  input  logic [IMM_W-1:0]  pred_imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              invalid_flag
);
  localparam int unsigned LANE_W = FP_W;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned N_OPS  = 2;

  logic                  rst_sync_n;
  logic [FP_W-1:0]       ops [N_OPS];
  fp_class_t             cls [N_OPS];
  rel_code_e             code;
  logic                  unord, eq, lt, hit, inv_c;
  logic [LANE_W-1:0]     mask;
  logic [DATA_W-1:0]     res_d, res_q;
  logic                  vld_d, vld_q, inv_d, inv_q;

  fcmp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign ops[0] = dst_in[LANE_W-1:0];
  assign ops[1] = src_in;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fcmp_classify u_cls (.op(ops[g]), .cls(cls[g]));
  end

  fcmp_order u_ord (
    .lhs(cls[0]), .rhs(cls[1]), .unord(unord), .eq(eq), .lt(lt)
  );

  assign code = rel_code_e'(pred_imm[SEL_W-1:0]);

  fcmp_pred_eval u_eval (
    .code(code), .unord(unord), .eq(eq), .lt(lt),
    .any_snan(cls[0].is_snan | cls[1].is_snan),
    .any_qnan(cls[0].is_qnan | cls[1].is_qnan),
    .hit(hit), .invalid(inv_c)
  );

  always_comb begin
    mask  = {LANE_W{hit}};
    vld_d = in_valid;
    res_d = res_q;
    inv_d = inv_q;
    if (in_valid) begin
      res_d = {dst_in[DATA_W-1:LANE_W], mask};
      inv_d = inv_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      inv_q <= inv_d;
    end
  end

  assign out_valid    = vld_q;
  assign result       = res_q;
  assign invalid_flag = inv_q;

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == $past(in_valid));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(result) && $stable(invalid_flag)));
  // R3
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> result[DATA_W-1:LANE_W] == $past(dst_in[DATA_W-1:LANE_W]));
  // R2
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (result[LANE_W-1:0] == '0 || result[LANE_W-1:0] == '1));
  // R8
  snan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (cls[0].is_snan || cls[1].is_snan)) |=> invalid_flag);
  // R6
  nan_eq_false_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && unord && pred_imm[SEL_W-1:0] == 3'd0) |=> result[LANE_W-1:0] == '0);
  // R7
  zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && cls[0].is_zero && cls[1].is_zero && pred_imm[SEL_W-1:0] == 3'd0)
    |=> result[LANE_W-1:0] == '1);
endmodule

// File: tb/tb_fcmp_mask_unit.sv
`timescale 1ns/1ps
module tb_fcmp_mask_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] dst_in = '0;
  logic [31:0]  src_in = '0;
  logic [7:0]   pred_imm = '0;
  logic         out_valid;
  logic [127:0] result;
  logic         invalid_flag;

  int errors = 0;
  int checks = 0;
  string pend_tag = "R10";

  logic         exp_v;
  logic [127:0] exp_r;
  logic         exp_i;

  always #2 clk = ~clk;

  fcmp_mask_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_in(dst_in),
    .src_in(src_in), .pred_imm(pred_imm), .out_valid(out_valid),
    .result(result), .invalid_flag(invalid_flag)
  );

  function automatic real to_real(input logic [31:0] x);
    int e;
    real v;
    e = int'(x[30:23]);
    if (e == 255)    v = 1.0e300;
    else if (e == 0) v = real'(int'(x[22:0])) * (2.0 ** (-149));
    else             v = (1.0 + real'(int'(x[22:0])) / 8388608.0) * (2.0 ** (e - 127));
    return x[31] ? -v : v;
  endfunction

  function automatic bit nan_of(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [32:0] ref_eval(input logic [31:0] a, input logic [31:0] b,
                                           input logic [7:0] imm);
    real ra, rb;
    bit un, t, inv, sn, qn, magrel;
    int p;
    ra = to_real(a);
    rb = to_real(b);
    un = nan_of(a) || nan_of(b);
    p = int'(imm[2:0]);
    case (p)
      0: t = !un && (ra == rb);
      1: t = !un && (ra < rb);
      2: t = !un && (ra <= rb);
      3: t = un;
      4: t = un || (ra != rb);
      5: t = un || !(ra < rb);
      6: t = un || !(ra <= rb);
      default: t = !un;
    endcase
    sn = (nan_of(a) && !a[22]) || (nan_of(b) && !b[22]);
    qn = (nan_of(a) && a[22]) || (nan_of(b) && b[22]);
    magrel = (p == 1) || (p == 2) || (p == 5) || (p == 6);
    inv = sn || (qn && magrel);
    return {inv, {32{t}}};
  endfunction

  // reference model updated on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0; exp_r <= '0; exp_i <= 1'b0;
    end else begin
      logic [32:0] m;
      m = ref_eval(dst_in[31:0], src_in, pred_imm);
      exp_v <= in_valid;
      if (in_valid) begin
        exp_r <= {dst_in[127:32], m[31:0]};
        exp_i <= m[32];
      end
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== exp_v || result !== exp_r || invalid_flag !== exp_i) begin
      errors++;
      $display("FAIL %s: got v=%0b r=%h i=%0b expected v=%0b r=%h i=%0b",
               tag, out_valid, result, invalid_flag, exp_v, exp_r, exp_i);
    end
  endtask

  task automatic step(input logic v, input logic [127:0] d, input logic [31:0] s,
                      input logic [7:0] imm, input string tag);
    @(negedge clk);
    compare(pend_tag);
    in_valid = v; dst_in = d; src_in = s; pred_imm = imm;
    pend_tag = tag;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 12)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7F80_0000;
      3: return 32'hFF80_0000;
      4: return 32'h7FC0_0000;
      5: return 32'h7F80_0001;
      6: return 32'h3F80_0000;
      7: return 32'hBF80_0000;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [127:0] updst(input logic [31:0] lane);
    return {$urandom, $urandom, $urandom, lane};
  endfunction

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    compare("R10");
    rst_n = 1'b1;
    repeat (3) step(1'b0, '0, '0, '0, "R10");
    // R1 R2: every code on ordered pairs
    for (int p = 0; p < 8; p++) begin
      step(1'b1, updst(32'h3F80_0000), 32'h4000_0000, 8'(p), "R1");
      step(1'b1, updst(32'h4000_0000), 32'h3F80_0000, 8'(p), "R2");
      step(1'b1, updst(32'h3F80_0000), 32'h3F80_0000, 8'(p), "R1");
    end
    // R7: signed zero, negatives, infinities
    step(1'b1, updst(32'h0000_0000), 32'h8000_0000, 8'd0, "R7");
    step(1'b1, updst(32'h8000_0000), 32'h0000_0000, 8'd1, "R7");
    step(1'b1, updst(32'hC000_0000), 32'hBF80_0000, 8'd1, "R7");
    step(1'b1, updst(32'hBF80_0000), 32'hC000_0000, 8'd2, "R7");
    step(1'b1, updst(32'hBF80_0000), 32'h3F80_0000, 8'd1, "R7");
    step(1'b1, updst(32'h7F80_0000), 32'h3F80_0000, 8'd6, "R7");
    step(1'b1, updst(32'hFF80_0000), 32'h7F80_0000, 8'd1, "R7");
    step(1'b1, updst(32'h7F80_0000), 32'h7F80_0000, 8'd0, "R7");
    // R5 R6 R8: NaNs on both sides, back-to-back
    for (int p = 0; p < 8; p++) begin
      step(1'b1, updst(32'h7FC0_0000), 32'h3F80_0000, 8'(p), "R6");
      step(1'b1, updst(32'h3F80_0000), 32'hFF80_0001, 8'(p), "R8");
      step(1'b1, updst(32'h3F80_0000), 32'h3F80_0000, 8'(p), "R5");
    end
    // R4: upper immediate bits set
    for (int p = 0; p < 8; p++)
      step(1'b1, updst(32'h4000_0000), 32'h7FC0_0001, 8'(8'hF8 | p), "R4");
    // R9: idle cycles hold, then a single strobe
    step(1'b1, updst(32'h3F80_0000), 32'h4000_0000, 8'd1, "R9");
    repeat (4) step(1'b0, updst($urandom), $urandom, $urandom, "R9");
    // R3 and mixed traffic
    for (int i = 0; i < 300; i++)
      step(1'(($urandom % 4) != 0), updst(pick()), pick(), 8'($urandom), "R3");
    step(1'b0, '0, '0, '0, "R9");
    step(1'b0, '0, '0, '0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule